// File: doc/BRIEF.md
# Per-Pin Pad Function Multiplexer

This block owns a bank of pads and decides, pin by pin, who drives each one. Every pin can be handed to the GPIO controller or to one of four alternate peripheral functions. A separate switch picks where the pad's output enable comes from. It can follow the selected source, or it can be pinned by a software-written, active-low override bit. The block also drives the static pad controls: input enable, Schmitt trigger, pull-up, pull-down and a 3-bit drive-strength code. The code selects 6 mA plus 3 mA per step, up to 27 mA.

Software programs the bank through a simple single-cycle register bus. Each pin owns two 32-bit words: a pad configuration word and a mux word. Writes are captured on the clock edge. Read data is combinational from the address. The bus is a control path with no data stream, so it has no valid/ready handshake and is never back-pressured. Every access completes in the cycle it is presented. Incoming pad data is gated by input enable and is then fanned out to the GPIO side and to the selected alternate function. The output path stays readable while the pin is driving.

Top module: `pinmux_bank`

## Requirements
- R1: The configuration word of pin p sits at byte address 8p and its mux word at 8p+4. Address bits 1:0 are ignored. A write takes effect at the next rising clock edge. A read returns configuration bits 7:0 or mux bits 3:0, with all higher bits 0, in the same cycle.
- R2: After reset every configuration word reads 0x80 and every mux word reads 0. Every pad then has pad_oe=0 and pad_ie=0.
- R3: With mux bit 2 set, pad_out follows gpio_out. If mux bit 3 is also set, pad_oe follows gpio_oe.
- R4: With mux bit 3 clear, pad_oe equals the inverse of configuration bit 7, whatever the selected source requests.
- R5: With mux bit 2 clear, the alternate function numbered by mux bits 1:0 drives pad_out. If mux bit 3 is set, that function also drives pad_oe.
- R6: gpio_in equals pad_in AND configuration bit 5 (pad_ie). This holds even while the pin drives its output.
- R7: Configuration bit 3 requests pull-up and bit 4 requests pull-down. When both are set, only pad_pu is asserted.
- R8: In alternate mode, only the selected function's alt_in receives the gated pad input, and the other three see 0. In GPIO mode, all four alt_in bits of the pin are 0.
- R9: Addresses at or above 8 × NUM_PINS read 0, and writes to them change no register.
- R10: Configuration bits 2:0 appear unchanged on pad_ds, and bit 6 appears on pad_st.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| gpio_out | input | NUM_PINS | Output data from the GPIO controller |
| gpio_oe | input | NUM_PINS | Output enable from the GPIO controller |
| gpio_in | output | NUM_PINS | Gated pad data toward the GPIO controller |
| alt_out | input | NUM_PINS*4 | Alternate function output data, index 4p+f |
| alt_oe | input | NUM_PINS*4 | Alternate function output enable, index 4p+f |
| alt_in | output | NUM_PINS*4 | Pad data toward the alternate functions, index 4p+f |
| pad_in | input | NUM_PINS | Level seen at each pad |
| pad_out | output | NUM_PINS | Output data to each pad |
| pad_oe | output | NUM_PINS | Output enable to each pad |
| pad_ie | output | NUM_PINS | Input enable to each pad |
| pad_st | output | NUM_PINS | Schmitt trigger enable |
| pad_pu | output | NUM_PINS | Pull-up enable |
| pad_pd | output | NUM_PINS | Pull-down enable |
| pad_ds | output | NUM_PINS*3 | Drive-strength code, bits 3p+2:3p |

## Verification
The assertions check four things on every cycle: the two pulls are never both on, no GPIO input passes while input enable is low, a pin never presents pad data to more than one alternate function, and a pin with its switch clear shows the override bit on its output enable. They also check that a write outside the bank leaves all storage untouched. Only the bench scenarios can show the address decode and read-back values, the reset contents, the routing of output data from GPIO and from each of the four functions, and the pass-through of drive code and Schmitt bit.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
  localparam int BUS_W   = 32;
  localparam int FN_W    = 2;
  localparam int NUM_FN  = 1 << FN_W;
  localparam int DS_W    = 3;
  localparam int CFG_W   = 8;
  localparam int MUX_W   = 4;

  // Field order follows the bit positions software decodes.
  typedef struct packed {
    logic            oe_n;     // bit 7: forced output enable, active low
    logic            schmitt;  // bit 6
    logic            in_en;    // bit 5
    logic            pull_dn;  // bit 4
    logic            pull_up;  // bit 3
    logic [DS_W-1:0] drive;    // bits 2:0
  } pad_cfg_t;

  typedef struct packed {
    logic            oe_src;   // bit 3: 1 = output enable from selected source
    logic            use_gpio; // bit 2
    logic [FN_W-1:0] fn;       // bits 1:0
  } mux_cfg_t;

  localparam pad_cfg_t CFG_RESET = '{oe_n: 1'b1, drive: '0, default: 1'b0};
  localparam mux_cfg_t MUX_RESET = '{fn: '0, default: 1'b0};
endpackage

// File: rtl/pinmux_regfile.sv
module pinmux_regfile
  import pinmux_pkg::*;
#(
  parameter int NUM_PINS = 49,
  parameter int ADDR_W   = 9
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [ADDR_W-1:0]              addr,
  input  logic                           we,
  input  logic [BUS_W-1:0]               wdata,
  output logic [BUS_W-1:0]               rdata,
  output pad_cfg_t [NUM_PINS-1:0]        cfg_q,
  output mux_cfg_t [NUM_PINS-1:0]        mux_q
);
  localparam int IDX_W = ADDR_W - 3;

  logic [IDX_W-1:0] pin_idx;
  logic             sel_mux;
  logic             hit;

  assign pin_idx = addr[ADDR_W-1:3];
  assign sel_mux = addr[2];
  assign hit     = int'(pin_idx) < NUM_PINS;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin_regs
    logic wr_here;
    assign wr_here = we && hit && (int'(pin_idx) == p);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[p] <= CFG_RESET;
        mux_q[p] <= MUX_RESET;
      end else if (wr_here) begin
        if (sel_mux) mux_q[p] <= mux_cfg_t'(wdata[MUX_W-1:0]);
        else         cfg_q[p] <= pad_cfg_t'(wdata[CFG_W-1:0]);
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (hit) begin
      if (sel_mux) rdata[MUX_W-1:0] = mux_q[pin_idx];
      else         rdata[CFG_W-1:0] = cfg_q[pin_idx];
    end
  end
endmodule

// File: rtl/pinmux_pin_route.sv
module pinmux_pin_route
  import pinmux_pkg::*;
(
  input  pad_cfg_t          cfg,
  input  mux_cfg_t          mux,
  input  logic              gpio_out,
  input  logic              gpio_oe,
  output logic              gpio_in,
  input  logic [NUM_FN-1:0] alt_out,
  input  logic [NUM_FN-1:0] alt_oe,
  output logic [NUM_FN-1:0] alt_in,
  input  logic              pad_in,
  output logic              pad_out,
  output logic              pad_oe,
  output logic              pad_ie,
  output logic              pad_st,
  output logic              pad_pu,
  output logic              pad_pd,
  output logic [DS_W-1:0]   pad_ds
);
  logic src_out;
  logic src_oe;
  logic in_gated;

  always_comb begin
    if (mux.use_gpio) begin
      src_out = gpio_out;
      src_oe  = gpio_oe;
    end else begin
      src_out = alt_out[mux.fn];
      src_oe  = alt_oe[mux.fn];
    end
  end

  assign pad_out  = src_out;
  assign pad_oe   = mux.oe_src ? src_oe : ~cfg.oe_n;
  assign in_gated = pad_in & cfg.in_en;
  assign gpio_in  = in_gated;

  for (genvar f = 0; f < NUM_FN; f++) begin : g_alt_in
    assign alt_in[f] = in_gated && !mux.use_gpio && (int'(mux.fn) == f);
  end

  assign pad_ie = cfg.in_en;
  assign pad_st = cfg.schmitt;
  assign pad_pu = cfg.pull_up;
  assign pad_pd = cfg.pull_dn & ~cfg.pull_up;   // pull-up wins a conflict
  assign pad_ds = cfg.drive;
endmodule

// File: rtl/pinmux_bank.sv
module pinmux_bank
  import pinmux_pkg::*;
#(
  parameter int NUM_PINS = 49,
  parameter int ADDR_W   = $clog2(NUM_PINS * 8)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic                       bus_we,
  input  logic [31:0]                bus_wdata,
  output logic [31:0]                bus_rdata,
  input  logic [NUM_PINS-1:0]        gpio_out,
  input  logic [NUM_PINS-1:0]        gpio_oe,
  output logic [NUM_PINS-1:0]        gpio_in,
  input  logic [NUM_PINS*4-1:0]      alt_out,
  input  logic [NUM_PINS*4-1:0]      alt_oe,
  output logic [NUM_PINS*4-1:0]      alt_in,
  input  logic [NUM_PINS-1:0]        pad_in,
  output logic [NUM_PINS-1:0]        pad_out,
  output logic [NUM_PINS-1:0]        pad_oe,
  output logic [NUM_PINS-1:0]        pad_ie,
  output logic [NUM_PINS-1:0]        pad_st,
  output logic [NUM_PINS-1:0]        pad_pu,
  output logic [NUM_PINS-1:0]        pad_pd,
  output logic [NUM_PINS*3-1:0]      pad_ds
);
  pad_cfg_t [NUM_PINS-1:0] cfg_q;
  mux_cfg_t [NUM_PINS-1:0] mux_q;

  pinmux_regfile #(
    .NUM_PINS(NUM_PINS),
    .ADDR_W  (ADDR_W)
  ) u_regs (
    .clk  (clk),
    .rst_n(rst_n),
    .addr (bus_addr),
    .we   (bus_we),
    .wdata(bus_wdata),
    .rdata(bus_rdata),
    .cfg_q(cfg_q),
    .mux_q(mux_q)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    pinmux_pin_route u_route (
      .cfg     (cfg_q[p]),
      .mux     (mux_q[p]),
      .gpio_out(gpio_out[p]),
      .gpio_oe (gpio_oe[p]),
      .gpio_in (gpio_in[p]),
      .alt_out (alt_out[p*NUM_FN +: NUM_FN]),
      .alt_oe  (alt_oe[p*NUM_FN +: NUM_FN]),
      .alt_in  (alt_in[p*NUM_FN +: NUM_FN]),
      .pad_in  (pad_in[p]),
      .pad_out (pad_out[p]),
      .pad_oe  (pad_oe[p]),
      .pad_ie  (pad_ie[p]),
      .pad_st  (pad_st[p]),
      .pad_pu  (pad_pu[p]),
      .pad_pd  (pad_pd[p]),
      .pad_ds  (pad_ds[p*DS_W +: DS_W])
    );
  end
endmodule

// File: rtl/pinmux_bank_chk.sv
module pinmux_bank_chk
  import pinmux_pkg::*;
#(
  parameter int NUM_PINS = 49,
  parameter int ADDR_W   = 9
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [ADDR_W-1:0]       bus_addr,
  input logic                    bus_we,
  input logic [NUM_PINS-1:0]     gpio_in,
  input logic [NUM_PINS*4-1:0]   alt_in,
  input logic [NUM_PINS-1:0]     pad_oe,
  input logic [NUM_PINS-1:0]     pad_ie,
  input logic [NUM_PINS-1:0]     pad_pu,
  input logic [NUM_PINS-1:0]     pad_pd,
  input pad_cfg_t [NUM_PINS-1:0] cfg_q,
  input mux_cfg_t [NUM_PINS-1:0] mux_q
);
  assert_pulls_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_pd) == '0);

  assert_input_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gpio_in & ~pad_ie) == '0);

  assert_oob_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && int'(bus_addr[ADDR_W-1:3]) >= NUM_PINS) |=> ($stable(cfg_q) && $stable(mux_q)));

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
    assert_alt_in_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(alt_in[p*NUM_FN +: NUM_FN]));

    assert_forced_oe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !mux_q[p].oe_src |-> (pad_oe[p] == ~cfg_q[p].oe_n));
  end
endmodule

bind pinmux_bank pinmux_bank_chk #(
  .NUM_PINS(NUM_PINS),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .bus_addr(bus_addr),
  .bus_we  (bus_we),
  .gpio_in (gpio_in),
  .alt_in  (alt_in),
  .pad_oe  (pad_oe),
  .pad_ie  (pad_ie),
  .pad_pu  (pad_pu),
  .pad_pd  (pad_pd),
  .cfg_q   (cfg_q),
  .mux_q   (mux_q)
);

// File: tb/sim_pinmux_bank.sv
module sim_pinmux_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 49;
  localparam int AW = 9;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic            bus_we = 1'b0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [NP-1:0]   gpio_out = '0, gpio_oe = '0, gpio_in;
  logic [NP*4-1:0] alt_out = '0, alt_oe = '0, alt_in;
  logic [NP-1:0]   pad_in = '0;
  logic [NP-1:0]   pad_out, pad_oe, pad_ie, pad_st, pad_pu, pad_pd;
  logic [NP*3-1:0] pad_ds;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pinmux_bank u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .gpio_out(gpio_out), .gpio_oe(gpio_oe), .gpio_in(gpio_in),
    .alt_out(alt_out), .alt_oe(alt_oe), .alt_in(alt_in),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_ie(pad_ie),
    .pad_st(pad_st), .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_ds(pad_ds)
  );

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic reg_wr(int addr, logic [31:0] data);
    @(negedge clk);
    bus_addr  = AW'(addr);
    bus_wdata = data;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
    #1;
  endtask

  task automatic reg_rd(int addr, output logic [31:0] data);
    @(negedge clk);
    bus_addr = AW'(addr);
    #1;
    data = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    reg_rd(0, d);      check("R2", "pin0 cfg", 64'(d), 64'h80);
    reg_rd(4, d);      check("R2", "pin0 mux", 64'(d), 64'h0);
    reg_rd(48*8, d);   check("R2", "pin48 cfg", 64'(d), 64'h80);
    check("R2", "pad_oe all", 64'(pad_oe), 64'h0);
    check("R2", "pad_ie all", 64'(pad_ie), 64'h0);
  endtask

  task automatic t_regmap();
    logic [31:0] d;
    reg_wr(5*8, 32'hFFFF_FFFF);
    reg_rd(5*8, d);     check("R1", "pin5 cfg readback", 64'(d), 64'hFF);
    reg_wr(5*8+4, 32'hFFFF_FFFF);
    reg_rd(5*8+4, d);   check("R1", "pin5 mux readback", 64'(d), 64'hF);
    reg_wr(7*8+4+3, 32'h6);
    reg_rd(7*8+4, d);   check("R1", "low addr bits ignored", 64'(d), 64'h6);
    reg_rd(6*8, d);     check("R1", "neighbour untouched", 64'(d), 64'h80);
  endtask

  task automatic t_gpio();
    reg_wr(10*8+4, 32'hC);
    alt_out = '1;
    gpio_out[10] = 1'b1; gpio_oe[10] = 1'b1; #1;
    check("R3", "pad_out gpio high", 64'(pad_out[10]), 64'h1);
    check("R3", "pad_oe gpio", 64'(pad_oe[10]), 64'h1);
    gpio_out[10] = 1'b0; gpio_oe[10] = 1'b0; #1;
    check("R3", "pad_out gpio low", 64'(pad_out[10]), 64'h0);
    check("R3", "pad_oe gpio off", 64'(pad_oe[10]), 64'h0);
    alt_out = '0;
  endtask

  task automatic t_alt();
    for (int f = 0; f < 4; f++) begin
      reg_wr(20*8+4, 32'(8 | f));
      alt_out = '0; alt_oe = '0;
      alt_out[20*4+f] = 1'b1; alt_oe[20*4+f] = 1'b1;
      gpio_out[20] = 1'b0; #1;
      check("R5", $sformatf("fn%0d out high", f), 64'(pad_out[20]), 64'h1);
      check("R5", $sformatf("fn%0d oe", f), 64'(pad_oe[20]), 64'h1);
      alt_out = '1; alt_out[20*4+f] = 1'b0; alt_oe = '1; alt_oe[20*4+f] = 1'b0; #1;
      check("R5", $sformatf("fn%0d out low", f), 64'(pad_out[20]), 64'h0);
      check("R5", $sformatf("fn%0d oe off", f), 64'(pad_oe[20]), 64'h0);
    end
    alt_out = '0; alt_oe = '0;
  endtask

  task automatic t_forced();
    reg_wr(30*8+4, 32'h4);
    reg_wr(30*8, 32'h00);
    gpio_oe[30] = 1'b0; #1;
    check("R4", "override on vs gpio_oe 0", 64'(pad_oe[30]), 64'h1);
    reg_wr(30*8, 32'h80);
    gpio_oe[30] = 1'b1; #1;
    check("R4", "override off vs gpio_oe 1", 64'(pad_oe[30]), 64'h0);
    gpio_oe[30] = 1'b0;
  endtask

  task automatic t_input();
    reg_wr(40*8+4, 32'hA);
    reg_wr(40*8, 32'h20);
    pad_in[40] = 1'b1; #1;
    check("R6", "gpio_in enabled", 64'(gpio_in[40]), 64'h1);
    check("R8", "alt_in slice fn2", 64'(alt_in[40*4 +: 4]), 64'h4);
    reg_wr(40*8, 32'h00);
    check("R6", "gpio_in gated", 64'(gpio_in[40]), 64'h0);
    check("R8", "alt_in gated", 64'(alt_in[40*4 +: 4]), 64'h0);
    reg_wr(40*8+4, 32'hC);
    reg_wr(40*8, 32'h20);
    gpio_out[40] = 1'b1; gpio_oe[40] = 1'b1; #1;
    check("R6", "readable while driving", 64'(gpio_in[40]), 64'h1);
    check("R6", "pin driving", 64'(pad_oe[40]), 64'h1);
    check("R8", "alt_in zero in gpio mode", 64'(alt_in[40*4 +: 4]), 64'h0);
    pad_in[40] = 1'b0; gpio_out[40] = 1'b0; gpio_oe[40] = 1'b0;
  endtask

  task automatic t_pull();
    reg_wr(3*8, 32'h18);
    check("R7", "both set pu", 64'(pad_pu[3]), 64'h1);
    check("R7", "both set pd", 64'(pad_pd[3]), 64'h0);
    reg_wr(3*8, 32'h10);
    check("R7", "pd only pd", 64'(pad_pd[3]), 64'h1);
    check("R7", "pd only pu", 64'(pad_pu[3]), 64'h0);
    reg_wr(3*8, 32'h08);
    check("R7", "pu only pu", 64'(pad_pu[3]), 64'h1);
  endtask

  task automatic t_drive();
    reg_wr(48*8, 32'h45);
    check("R10", "ds code 5", 64'(pad_ds[48*3 +: 3]), 64'h5);
    check("R10", "schmitt on", 64'(pad_st[48]), 64'h1);
    reg_wr(48*8, 32'h07);
    check("R10", "ds code 7", 64'(pad_ds[48*3 +: 3]), 64'h7);
    check("R10", "schmitt off", 64'(pad_st[48]), 64'h0);
  endtask

  task automatic t_oob();
    logic [31:0] d;
    reg_wr(NP*8, 32'hFF);
    reg_rd(NP*8, d);     check("R9", "first oob read", 64'(d), 64'h0);
    reg_wr(511, 32'hF);
    reg_rd(NP*8+4, d);   check("R9", "oob mux read", 64'(d), 64'h0);
    reg_rd(48*8, d);     check("R9", "pin48 cfg kept", 64'(d), 64'h07);
    reg_rd(0, d);        check("R9", "pin0 cfg kept", 64'(d), 64'h80);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_regmap();
    t_gpio();
    t_alt();
    t_forced();
    t_input();
    t_pull();
    t_drive();
    t_oob();
    finish_run();
  end
endmodule